// File: doc/BRIEF.md
# I2C Byte-Memory Slave Front End

This block sits between a two-wire serial bus and a 2048-byte memory array. It watches oversampled SCL and SDA lines and answers a host that addresses it with a fixed 4-bit device code. The three most significant memory address bits travel inside the address byte. The low eight bits follow as a separate byte address. The block pulls SDA low through an open-drain enable. It drives a simple memory port with address, write data, write strobe and read data, and it raises a busy flag while a modelled internal write is in progress.

A persistent pointer holds the location after the one last touched. A read that carries no byte address continues from that pointer. This allows single-byte and streaming reads, either from the pointer or from an address that a short dummy write sets first. A byte write commits on STOP and starts a fixed-length internal write cycle. During that cycle the block ignores the bus completely, so a host learns that the write has finished by repeating START plus address until the address is acknowledged.

The control is one state machine:
- `S_IDLE` waits for START.
- `S_DEV` receives the address byte.
- `S_WADDR` receives the byte address.
- `S_WDATA` receives the data byte.
- `S_ACK` drives the acknowledge bit.
- `S_TX` shifts a data byte out.
- `S_RACK` samples the host's acknowledge.
- `S_SKIP` stays silent until the next START or STOP.

The transitions are:
- STOP goes to `S_IDLE` from any state.
- START goes to `S_DEV`, or stays in `S_IDLE` while busy.
- A completed byte in `S_DEV` goes to `S_ACK` on a device code match and to `S_SKIP` otherwise.
- A completed byte in `S_WADDR` or `S_WDATA` goes to `S_ACK`.
- `S_ACK` ends into `S_WADDR`, `S_WDATA`, `S_TX` or `S_SKIP`, as recorded when the byte was taken.
- `S_TX` goes to `S_RACK` after eight bits.
- `S_RACK` goes back to `S_TX` on a host ACK and to `S_SKIP` on a NACK.

Top module: `eep_i2c_slave`

## Requirements
- R1: After reset `sda_oe`, `busy` and `mem_we` are 0, and the pointer is 0, so the first current-address read returns the byte at location 0.
- R2: The address byte is received MSB first as device code 1010, then A10, A9, A8, then R/W (1 = read, 0 = write). On a code match the block acknowledges by holding SDA low during the ninth clock. On a mismatch it neither acknowledges nor drives SDA until the next START or STOP.
- R3: A write is the address byte with R/W=0, a byte address carrying A7..A0, and one data byte, each acknowledged. On the following STOP, `mem_we` pulses for one clock at address {A10..A8, A7..A0} with that data.
- R4: After a write commits, `busy` is high for exactly `WCYC_CLKS` clocks. During that time START is ignored, the address byte is not acknowledged and SDA is never driven. Once `busy` falls, an address poll is acknowledged and the write may continue with its byte address.
- R5: After any read or write of location n, a read with no byte address returns the byte at n+1.
- R6: A current-address read acknowledges the address byte and sends the byte at the pointer D7 first. The A10..A8 bits of a read address byte are ignored.
- R7: A dummy write (address byte with R/W=0 plus byte address), then a repeated START and an address byte with R/W=1, returns the byte at the given address.
- R8: In a read, each host ACK makes the block send the next byte, and the pointer wraps from 2047 to 0.
- R9: After a host NACK the block releases SDA and stays silent through further clocks until START or STOP.
- R10: A transfer that ends before a data byte is taken writes nothing and leaves `busy` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the bus |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Raw serial clock line |
| sda_i | input | 1 | Raw serial data line as seen on the bus |
| sda_oe | output | 1 | 1 pulls SDA low (open drain) |
| mem_addr | output | 11 | Memory address, equal to the pointer |
| mem_wdata | output | 8 | Memory write data |
| mem_we | output | 1 | One-clock memory write strobe |
| mem_rdata | input | 8 | Memory read data, valid one clock after `mem_addr` |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Reads are tried with no byte address, both first after reset and after earlier reads and writes. They are also tried with a dummy-write address, and as a stream running across the top of memory. Comparing the returned bytes against a computed pattern tells pointer persistence apart from address loading and from wrap-around. Writes are followed by immediate polling, which must first be refused and later accepted, and then by a write that reuses the accepted poll. A wrong device code and an extra byte clocked after a NACK show whether the block keeps off the bus when it should.

// File: rtl/eep_pkg.sv
package eep_pkg;
    localparam int MEM_AW = 11;
    localparam int LO_W   = 8;
    localparam int HI_W   = MEM_AW - LO_W;
    localparam logic [3:0] DEV_CODE = 4'b1010;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEV,
        S_WADDR,
        S_WDATA,
        S_ACK,
        S_TX,
        S_RACK,
        S_SKIP
    } st_e;

    typedef enum logic [1:0] {
        AF_WADDR,
        AF_WDATA,
        AF_TX,
        AF_SKIP
    } after_e;
endpackage

// File: rtl/eep_bus_sync.sv
module eep_bus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    logic [STAGES-1:0] scl_ff;
    logic [STAGES-1:0] sda_ff;
    logic scl_q;
    logic sda_q;
    logic scl_s;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_ff <= '1;
            sda_ff <= '1;
            scl_q  <= 1'b1;
            sda_q  <= 1'b1;
        end else begin
            scl_ff <= {scl_ff[STAGES-2:0], scl_i};
            sda_ff <= {sda_ff[STAGES-2:0], sda_i};
            scl_q  <= scl_ff[STAGES-1];
            sda_q  <= sda_ff[STAGES-1];
        end
    end

    assign scl_s     = scl_ff[STAGES-1];
    assign sda_s     = sda_ff[STAGES-1];
    assign scl_rise  = scl_s & ~scl_q;
    assign scl_fall  = ~scl_s & scl_q;
    assign start_det = scl_s & scl_q & sda_q & ~sda_s;
    assign stop_det  = scl_s & scl_q & ~sda_q & sda_s;
endmodule

// File: rtl/eep_wr_timer.sv
module eep_wr_timer #(
    parameter int CYCLES = 5000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic kick,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (kick) begin
            cnt <= CW'(CYCLES);
        end else if (cnt != '0) begin
            cnt <= cnt - 1'b1;
        end
    end

    assign busy = (cnt != '0);
endmodule

// File: rtl/eep_addr_ptr.sv
module eep_addr_ptr #(
    parameter int AW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [AW-1:0] load_val,
    input  logic          inc,
    output logic [AW-1:0] ptr
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
        end else if (load) begin
            ptr <= load_val;
        end else if (inc) begin
            ptr <= ptr + 1'b1;
        end
    end
endmodule

// File: rtl/eep_i2c_slave.sv
module eep_i2c_slave
    import eep_pkg::*;
#(
    parameter int WCYC_CLKS   = 5000,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    output logic [MEM_AW-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    output logic              mem_we,
    input  logic [7:0]        mem_rdata,
    output logic              busy
);
    logic sda_s;
    logic scl_rise;
    logic scl_fall;
    logic start_det;
    logic stop_det;

    st_e    st_q;
    st_e    st_d;
    after_e after_q;

    logic [3:0]      bit_cnt;
    logic [7:0]      shreg;
    logic [7:0]      tx;
    logic [7:0]      wdata_q;
    logic [HI_W-1:0] hi_q;
    logic            wpend;
    logic            m_ack;

    logic              byte_done;
    logic              dev_hit;
    logic              edge_evt;
    logic              commit;
    logic              tx_load;
    logic              ptr_load;
    logic              ptr_inc;
    logic [MEM_AW-1:0] ld_val;

    eep_bus_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    eep_wr_timer #(.CYCLES(WCYC_CLKS)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .kick  (commit),
        .busy  (busy)
    );

    eep_addr_ptr #(.AW(MEM_AW)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (ptr_load),
        .load_val (ld_val),
        .inc      (ptr_inc),
        .ptr      (mem_addr)
    );

    assign byte_done = scl_fall && (bit_cnt == 4'd8);
    assign dev_hit   = (shreg[7:4] == DEV_CODE);
    assign edge_evt  = start_det | stop_det;
    assign ld_val    = {hi_q, shreg};

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= S_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // next state
    always_comb begin
        st_d = st_q;
        if (stop_det) begin
            st_d = S_IDLE;
        end else if (start_det) begin
            st_d = busy ? S_IDLE : S_DEV;
        end else begin
            unique case (st_q)
                S_IDLE: st_d = S_IDLE;
                S_DEV: begin
                    if (byte_done) st_d = dev_hit ? S_ACK : S_SKIP;
                end
                S_WADDR, S_WDATA: begin
                    if (byte_done) st_d = S_ACK;
                end
                S_ACK: begin
                    if (scl_fall) begin
                        unique case (after_q)
                            AF_WADDR: st_d = S_WADDR;
                            AF_WDATA: st_d = S_WDATA;
                            AF_TX:    st_d = S_TX;
                            AF_SKIP:  st_d = S_SKIP;
                        endcase
                    end
                end
                S_TX: begin
                    if (scl_fall && bit_cnt == 4'd7) st_d = S_RACK;
                end
                S_RACK: begin
                    if (scl_fall) st_d = m_ack ? S_TX : S_SKIP;
                end
                S_SKIP: st_d = S_SKIP;
            endcase
        end
    end

    // outputs and datapath strobes
    always_comb begin
        sda_oe    = (st_q == S_ACK) || ((st_q == S_TX) && !tx[7]);
        commit    = stop_det && wpend && !busy;
        mem_we    = commit;
        mem_wdata = wdata_q;
        tx_load   = !edge_evt && scl_fall &&
                    (((st_q == S_ACK) && (after_q == AF_TX)) ||
                     ((st_q == S_RACK) && m_ack));
        ptr_load  = !edge_evt && (st_q == S_WADDR) && byte_done;
        ptr_inc   = commit || tx_load;
    end

    // datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt <= '0;
            shreg   <= '0;
            tx      <= '1;
            wdata_q <= '0;
            hi_q    <= '0;
            wpend   <= 1'b0;
            m_ack   <= 1'b0;
            after_q <= AF_SKIP;
        end else if (edge_evt) begin
            bit_cnt <= '0;
            wpend   <= 1'b0;
        end else begin
            unique case (st_q)
                S_DEV, S_WADDR, S_WDATA: begin
                    if (scl_rise) begin
                        shreg   <= {shreg[6:0], sda_s};
                        bit_cnt <= bit_cnt + 1'b1;
                    end else if (byte_done) begin
                        bit_cnt <= '0;
                        if (st_q == S_DEV) begin
                            hi_q    <= shreg[3:1];
                            after_q <= shreg[0] ? AF_TX : AF_WADDR;
                        end else if (st_q == S_WADDR) begin
                            after_q <= AF_WDATA;
                        end else begin
                            wdata_q <= shreg;
                            wpend   <= 1'b1;
                            after_q <= AF_SKIP;
                        end
                    end
                end
                S_ACK: begin
                    if (tx_load) begin
                        tx      <= mem_rdata;
                        bit_cnt <= '0;
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        tx      <= {tx[6:0], 1'b1};
                        bit_cnt <= bit_cnt + 1'b1;
                    end
                end
                S_RACK: begin
                    if (scl_rise) begin
                        m_ack <= ~sda_s;
                    end else if (tx_load) begin
                        tx      <= mem_rdata;
                        bit_cnt <= '0;
                    end
                end
                S_IDLE, S_SKIP: begin
                    bit_cnt <= '0;
                end
            endcase
        end
    end
endmodule

// File: rtl/eep_i2c_slave_chk.sv
module eep_i2c_slave_chk #(
    parameter int WCYC_CLKS = 5000
) (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic mem_we,
    input logic busy
);
    int busy_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            busy_len <= 0;
        end else if (busy) begin
            busy_len <= busy_len + 1;
        end else begin
            busy_len <= 0;
        end
    end

    p_we_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> !mem_we);

    p_we_starts_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> busy);

    p_busy_from_we_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(mem_we));

    p_busy_len_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (busy_len == WCYC_CLKS));

    p_busy_silent_r4: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !sda_oe);

    p_oe_moves_scl_low_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i);
endmodule

bind eep_i2c_slave eep_i2c_slave_chk #(.WCYC_CLKS(WCYC_CLKS)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .scl_i  (scl_i),
    .sda_oe (sda_oe),
    .mem_we (mem_we),
    .busy   (busy)
);

// File: tb/sim_eep_i2c_slave.sv
module sim_eep_i2c_slave;
    localparam int Q  = 10;
    localparam int WC = 600;

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic        rst_n = 1'b0;
    logic        scl_m = 1'b1;
    logic        m_low = 1'b0;
    logic        sda_bus;
    logic        sda_oe;
    logic        mem_we;
    logic        busy;
    logic [10:0] mem_addr;
    logic [7:0]  mem_wdata;
    logic [7:0]  mem_rdata;
    logic [7:0]  mem [0:2047];

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    assign sda_bus = ~(m_low | sda_oe);

    eep_i2c_slave #(.WCYC_CLKS(WC), .SYNC_STAGES(2)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_m),
        .sda_i     (sda_bus),
        .sda_oe    (sda_oe),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata),
        .mem_we    (mem_we),
        .mem_rdata (mem_rdata),
        .busy      (busy)
    );

    function automatic logic [7:0] pat(int i);
        return 8'((i * 37) ^ (i >> 3) ^ 8'h5A);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 2048; i++) mem[i] <= pat(i);
            mem_rdata <= 8'h00;
        end else begin
            if (mem_we) mem[mem_addr] <= mem_wdata;
            mem_rdata <= mem[mem_addr];
        end
    end

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic bus_start();
        m_low = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        m_low = 1'b1; tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic bus_stop();
        m_low = 1'b1; tick(Q);
        scl_m = 1'b1; tick(Q);
        m_low = 1'b0; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output bit ack);
        for (int i = 7; i >= 0; i--) begin
            m_low = ~b[i]; tick(Q);
            scl_m = 1'b1;  tick(2 * Q);
            scl_m = 1'b0;  tick(Q);
        end
        m_low = 1'b0; tick(Q);
        scl_m = 1'b1; tick(Q);
        ack = ~sda_bus;
        tick(Q);
        scl_m = 1'b0; tick(Q);
    endtask

    task automatic rd_byte(output logic [7:0] b, input bit ack);
        m_low = 1'b0;
        for (int i = 7; i >= 0; i--) begin
            tick(Q);
            scl_m = 1'b1; tick(Q);
            b[i] = sda_bus;
            tick(Q);
            scl_m = 1'b0;
        end
        m_low = ack; tick(Q);
        scl_m = 1'b1; tick(2 * Q);
        scl_m = 1'b0; tick(Q);
        m_low = 1'b0;
    endtask

    task automatic cur_read(input logic [7:0] devb, output logic [7:0] b, output bit ack);
        bus_start();
        wr_byte(devb, ack);
        rd_byte(b, 1'b0);
        bus_stop();
    endtask

    task automatic set_ptr(input logic [10:0] a, output bit ok);
        bit a1, a2;
        bus_start();
        wr_byte({4'b1010, a[10:8], 1'b0}, a1);
        wr_byte(a[7:0], a2);
        ok = a1 & a2;
    endtask

    task automatic t_reset();
        logic [7:0] b;
        bit a;
        chk("R1 sda_oe", int'(sda_oe), 0);
        chk("R1 busy", int'(busy), 0);
        chk("R1 mem_we", int'(mem_we), 0);
        cur_read(8'hA1, b, a);
        chk("R2 ack on match", int'(a), 1);
        chk("R1 first read at 0", int'(b), int'(pat(0)));
    endtask

    task automatic t_current();
        logic [7:0] b;
        bit a;
        cur_read(8'hAB, b, a);
        chk("R6 ack", int'(a), 1);
        chk("R6 upper bits ignored", int'(b), int'(pat(1)));
        cur_read(8'hA1, b, a);
        chk("R5 pointer advance after read", int'(b), int'(pat(2)));
    endtask

    task automatic t_bad_code();
        logic [7:0] b;
        bit a;
        bus_start();
        wr_byte(8'h91, a);
        chk("R2 no ack on wrong code", int'(a), 0);
        rd_byte(b, 1'b0);
        chk("R2 silent after wrong code", int'(b), 8'hFF);
        bus_stop();
        cur_read(8'hA1, b, a);
        chk("R5 pointer untouched by wrong code", int'(b), int'(pat(3)));
    endtask

    task automatic t_write_poll();
        logic [7:0] b;
        bit a1, a2, a3, a, first_a;
        int polls;
        bus_start();
        wr_byte(8'hA6, a1);
        wr_byte(8'hA5, a2);
        wr_byte(8'h5C, a3);
        bus_stop();
        chk("R3 write acks", int'(a1 & a2 & a3), 1);
        tick(1);
        chk("R4 busy after write", int'(busy), 1);
        chk("R3 memory written", int'(mem[11'h3A5]), 8'h5C);
        polls   = 0;
        first_a = 1'b1;
        a       = 1'b0;
        while (polls < 8) begin
            bus_start();
            wr_byte(8'hA6, a);
            if (polls == 0) first_a = a;
            polls++;
            if (a) break;
            bus_stop();
        end
        chk("R4 first poll refused", int'(first_a), 0);
        chk("R4 poll accepted later", int'(a), 1);
        chk("R4 busy low at accepted poll", int'(busy), 0);
        wr_byte(8'h10, a2);
        wr_byte(8'hC3, a3);
        bus_stop();
        chk("R4 continued write acks", int'(a2 & a3), 1);
        chk("R3 continued write stored", int'(mem[11'h310]), 8'hC3);
        while (busy) tick(1);
        cur_read(8'hA1, b, a);
        chk("R5 pointer after write", int'(b), int'(pat(11'h311)));
    endtask

    task automatic t_random();
        logic [7:0] b;
        bit a, ok;
        set_ptr(11'h6F0, ok);
        bus_start();
        wr_byte(8'hA1, a);
        rd_byte(b, 1'b0);
        bus_stop();
        chk("R7 dummy write acks", int'(ok & a), 1);
        chk("R7 random read data", int'(b), int'(pat(11'h6F0)));
        chk("R10 no busy after dummy write", int'(busy), 0);
        chk("R10 memory unchanged", int'(mem[11'h6F0]), int'(pat(11'h6F0)));
        cur_read(8'hA1, b, a);
        chk("R5 pointer after random read", int'(b), int'(pat(11'h6F1)));
        set_ptr(11'h3A5, ok);
        bus_start();
        wr_byte(8'hA1, a);
        rd_byte(b, 1'b0);
        bus_stop();
        chk("R3 written byte read back", int'(b), 8'h5C);
    endtask

    task automatic t_seq_wrap();
        logic [7:0] b0, b1, b2, b3, bx;
        bit a, ok;
        set_ptr(11'h7FE, ok);
        bus_start();
        wr_byte(8'hA1, a);
        rd_byte(b0, 1'b1);
        rd_byte(b1, 1'b1);
        rd_byte(b2, 1'b1);
        rd_byte(b3, 1'b0);
        chk("R8 byte 2046", int'(b0), int'(pat(11'h7FE)));
        chk("R8 byte 2047", int'(b1), int'(pat(11'h7FF)));
        chk("R8 wrap to 0", int'(b2), int'(pat(0)));
        chk("R8 byte 1", int'(b3), int'(pat(1)));
        chk("R9 released after NACK", int'(sda_oe), 0);
        rd_byte(bx, 1'b0);
        chk("R9 silent after NACK", int'(bx), 8'hFF);
        bus_stop();
        cur_read(8'hA1, bx, a);
        chk("R8 pointer continues after wrap", int'(bx), int'(pat(2)));
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(5);
        t_reset();
        t_current();
        t_bad_code();
        t_write_poll();
        t_random();
        t_seq_wrap();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule